// File: doc/BRIEF.md
# Signed Tree Multiplier with Registered Product

This block multiplies two N-bit two's-complement numbers and delivers the full 2N-bit signed product one clock after a valid strobe. The default width is 4 by 4, which gives an 8-bit product. The arithmetic is combinational, and a single register stage sits at the output.

The product is rewritten as a sum of shifted partial-product rows. Each row is a copy of one operand's magnitude bits, and one bit of the other operand switches it on or off.

Rows whose weights are positive are summed by a balanced adder tree. The two rows that carry the weight of a sign bit are summed by a separate adder that works in parallel with that tree. A final stage subtracts the negative sum from the positive sum.

The lone product of the two sign bits has a positive weight of 2^(2N-2). It is merged into the highest positive row, where it overlaps no other bit.

With N=4 the add depth is three: two positive-tree levels, with the negative pair summed in parallel, followed by one subtraction. A serial chain would need four.

Top module: `tcm_tree_mul`

## Requirements
- R1: When `in_valid` is 1 at a rising clock edge, `prod_out` after that edge equals the signed product of `x_in` and `y_in`, read as two's-complement numbers. The result is a 2N-bit two's-complement value.
- R2: The product appears exactly one clock edge after the operands are presented with `in_valid` high.
- R3: `out_valid` is 1 in the cycle after each edge at which `in_valid` was 1, and 0 after each edge at which it was 0.
- R4: While `in_valid` is 0, `prod_out` keeps its last value, whatever `x_in` and `y_in` do.
- R5: While `rst_n` is 0, `prod_out` is 0 and `out_valid` is 0.
- R6: The most negative operand times the most negative operand gives +2^(2N-2). For N=4 that is 8'h40, so no bit is lost.
- R7: Multiplying by -1, an all-ones operand, returns the negation of the other operand, including for the most negative value. For N=4, -8 times -1 gives 8'h08.
- R8: A zero operand gives a zero product, whatever the other operand holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present and are to be multiplied |
| x_in | input | N | Multiplicand, two's complement |
| y_in | input | N | Multiplier, two's complement |
| prod_out | output | 2N | Registered signed product |
| out_valid | output | 1 | prod_out was updated at the last edge |

## Verification
The hardest case to reach is the one in which both sign bits are set. Here both negative rows are active and the folded sign-sign term sits at the top bit, so any error in carry or borrow at the top of the word shows only in that case. For N=4 every one of the 256 operand pairs is driven, which reaches it and every other sign combination. A second instance at N=8 receives random pairs, with the two extreme values forced at the start. Separate directed phases change the operands while the strobe is low, to show the held product, and assert reset in the middle of a run.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    // Number of binary levels needed to reduce `leaves` operands to one.
    function automatic int tcm_levels(input int leaves);
        int lv;
        int span;
        lv   = 0;
        span = 1;
        while (span < leaves) begin
            span = span * 2;
            lv   = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/tcm_row_gen.sv
// Builds the gated partial-product rows of a two's-complement product.
// Positive rows: x magnitude bits gated by each y magnitude bit.
// Negative rows: the two rows weighted by a sign bit.
// The sign-sign term is folded into the highest positive row.
module tcm_row_gen #(
    parameter int N = 4
) (
    input  logic [N-1:0]               x_in,
    input  logic [N-1:0]               y_in,
    output logic [N-2:0][2*N-1:0]      pos_rows,
    output logic [1:0][2*N-1:0]        neg_rows
);
    localparam int W    = 2 * N;
    localparam int P    = N - 1;
    localparam int PAD  = W - (N - 1);

    logic [W-1:0] x_mag;
    logic [W-1:0] y_mag;
    logic [W-1:0] sign_term;

    assign x_mag     = {{PAD{1'b0}}, x_in[N-2:0]};
    assign y_mag     = {{PAD{1'b0}}, y_in[N-2:0]};
    assign sign_term = {1'b0, x_in[N-1] & y_in[N-1], {(W-2){1'b0}}};

    for (genvar i = 0; i < P; i++) begin : g_pos
        logic [W-1:0] gated;
        assign gated = y_in[i] ? (x_mag << i) : '0;
        if (i == P - 1) begin : g_fold
            assign pos_rows[i] = gated | sign_term;
        end else begin : g_plain
            assign pos_rows[i] = gated;
        end
    end

    assign neg_rows[0] = x_in[N-1] ? (y_mag << (N - 1)) : '0;
    assign neg_rows[1] = y_in[N-1] ? (x_mag << (N - 1)) : '0;

endmodule

// File: rtl/tcm_sum_tree.sv
// Balanced binary adder tree; leaf count padded with zeros to a power of two.
module tcm_sum_tree
    import tcm_pkg::*;
#(
    parameter int LEAVES = 3,
    parameter int W      = 8
) (
    input  logic [LEAVES-1:0][W-1:0] leaf,
    output logic [W-1:0]             total
);
    localparam int DEPTH = tcm_levels(LEAVES);
    localparam int SLOTS = 1 << DEPTH;

    for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
        localparam int CNT = SLOTS >> l;
        logic [W-1:0] v [CNT];
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_j
                if (j < LEAVES) begin : g_in
                    assign v[j] = leaf[j];
                end else begin : g_zero
                    assign v[j] = '0;
                end
            end
        end else begin : g_add
            for (genvar j = 0; j < CNT; j++) begin : g_j
                assign v[j] = g_lvl[l-1].v[2*j] + g_lvl[l-1].v[2*j+1];
            end
        end
    end

    assign total = g_lvl[DEPTH].v[0];

endmodule

// File: rtl/tcm_tree_mul.sv
module tcm_tree_mul #(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [N-1:0]     x_in,
    input  logic [N-1:0]     y_in,
    output logic [2*N-1:0]   prod_out,
    output logic             out_valid
);
    localparam int W = 2 * N;
    localparam int P = N - 1;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] prod;
    } tcm_state_t;

    logic [P-1:0][W-1:0] pos_rows;
    logic [1:0][W-1:0]   neg_rows;
    logic [W-1:0]        pos_sum;
    logic [W-1:0]        neg_sum;
    tcm_state_t          st_d;
    tcm_state_t          st_q;

    tcm_row_gen #(.N(N)) u_rows (
        .x_in     (x_in),
        .y_in     (y_in),
        .pos_rows (pos_rows),
        .neg_rows (neg_rows)
    );

    tcm_sum_tree #(.LEAVES(P), .W(W)) u_pos_tree (
        .leaf  (pos_rows),
        .total (pos_sum)
    );

    tcm_sum_tree #(.LEAVES(2), .W(W)) u_neg_tree (
        .leaf  (neg_rows),
        .total (neg_sum)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.prod = pos_sum - neg_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_out  = st_q.prod;
    assign out_valid = st_q.vld;

endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N-1:0]   x_in,
    input logic [N-1:0]   y_in,
    input logic [2*N-1:0] prod_out,
    input logic           out_valid
);
    localparam int W = 2 * N;

    logic signed [W-1:0] x_ext;
    logic signed [W-1:0] y_ext;
    logic [N-1:0]        most_neg;
    logic [W-1:0]        top_pow;

    assign x_ext    = W'($signed(x_in));
    assign y_ext    = W'($signed(y_in));
    assign most_neg = {1'b1, {(N-1){1'b0}}};
    assign top_pow  = {2'b01, {(W-2){1'b0}}};

    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_out == W'($past(x_ext) * $past(y_ext))); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod_out)); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (prod_out == '0 && !out_valid)); // R5
    AST_MIN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_in == most_neg && y_in == most_neg) |=> prod_out == top_pow); // R6
    AST_ZERO_OPND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (x_in == '0 || y_in == '0)) |=> prod_out == '0); // R8

endmodule

bind tcm_tree_mul tcm_checker #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x_in      (x_in),
    .y_in      (y_in),
    .prod_out  (prod_out),
    .out_valid (out_valid)
);

// File: tb/tcm_tree_mul_test.sv
module tcm_tree_mul_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] xa = '0, ya = '0;
    logic [7:0] pa;
    logic va;
    logic in_valid8 = 1'b0;
    logic [7:0] xb = '0, yb = '0;
    logic [15:0] pb;
    logic vb;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tcm_tree_mul #(.N(4)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_in(xa), .y_in(ya), .prod_out(pa), .out_valid(va));

    tcm_tree_mul #(.N(8)) uut_w8 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid8),
        .x_in(xb), .y_in(yb), .prod_out(pb), .out_valid(vb));

    // {x, y, expected product} for N=4
    localparam logic [15:0] VEC [13] = '{
        {4'h0, 4'h0, 8'h00},
        {4'h1, 4'h1, 8'h01},
        {4'h7, 4'h7, 8'h31},
        {4'h8, 4'h8, 8'h40},
        {4'h8, 4'h7, 8'hC8},
        {4'h7, 4'h8, 8'hC8},
        {4'hF, 4'hF, 8'h01},
        {4'hF, 4'h8, 8'h08},
        {4'h3, 4'hF, 8'hFD},
        {4'h5, 4'hA, 8'hE2},
        {4'hC, 4'hD, 8'h0C},
        {4'h6, 4'h0, 8'h00},
        {4'h8, 4'h1, 8'hF8}
    };

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mul4(input logic [3:0] x, input logic [3:0] y);
        @(negedge clk);
        xa = x; ya = y; in_valid = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
        logic signed [3:0] xs, ys;
        logic signed [7:0] r;
        xs = x; ys = y;
        r = xs * ys;
        return r;
    endfunction

    function automatic logic [15:0] ref8(input logic [7:0] x, input logic [7:0] y);
        logic signed [7:0] xs, ys;
        logic signed [15:0] r;
        xs = x; ys = y;
        r = xs * ys;
        return r;
    endfunction

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        // R5: reset state
        repeat (2) @(negedge clk);
        chk8("R5 reset product", pa, 8'h00);
        chk8("R5 reset valid", {7'd0, va}, 8'h00);
        rst_n = 1'b1;

        // R1 table walk
        for (int i = 0; i < 13; i++) begin
            mul4(VEC[i][15:12], VEC[i][11:8]);
            chk8("R1 table", pa, VEC[i][7:0]);
        end

        // R2/R3: product and valid one edge after strobe
        @(negedge clk);
        in_valid = 1'b0; xa = 4'h3; ya = 4'h3;
        @(negedge clk);
        chk8("R3 valid low after idle", {7'd0, va}, 8'h00);
        xa = 4'h2; ya = 4'h5; in_valid = 1'b1;
        #2;
        chk8("R2 no change before edge", pa, 8'hF8);
        @(negedge clk);
        chk8("R2 product after one edge", pa, 8'h0A);
        chk8("R3 valid high", {7'd0, va}, 8'h01);

        // R4: inputs ignored while strobe low
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            xa = 4'(k * 3 + 1); ya = 4'(15 - k);
            @(negedge clk);
            chk8("R4 held product", pa, 8'h0A);
        end

        // R6: min by min
        mul4(4'h8, 4'h8);
        chk8("R6 min times min", pa, 8'h40);
        // R7: multiply by -1
        for (int v = 0; v < 16; v++) begin
            mul4(4'(v), 4'hF);
            chk8("R7 negate", pa, 8'(-$signed({{4{v[3]}}, 4'(v)})));
        end
        // R8: zero operand
        mul4(4'h0, 4'h9);
        chk8("R8 zero x", pa, 8'h00);
        mul4(4'hB, 4'h0);
        chk8("R8 zero y", pa, 8'h00);

        // R1 exhaustive for N=4
        for (int xi = 0; xi < 16; xi++) begin
            for (int yi = 0; yi < 16; yi++) begin
                mul4(4'(xi), 4'(yi));
                chk8("R1 exhaustive", pa, ref4(4'(xi), 4'(yi)));
            end
        end
        in_valid = 1'b0;

        // R1/R6 for N=8: extremes then random pairs
        @(negedge clk);
        xb = 8'h80; yb = 8'h80; in_valid8 = 1'b1;
        @(negedge clk);
        chk16("R6 N=8 min times min", pb, 16'h4000);
        xb = 8'h7F; yb = 8'h80;
        @(negedge clk);
        chk16("R1 N=8 max times min", pb, 16'hC080);
        for (int r = 0; r < 300; r++) begin
            logic [7:0] a, b;
            a = 8'($urandom); b = 8'($urandom);
            xb = a; yb = b;
            @(negedge clk);
            chk16("R1 N=8 random", pb, ref8(a, b));
        end
        in_valid8 = 1'b0;

        // R5: reset mid-run clears state
        mul4(4'h7, 4'h7);
        rst_n = 1'b0;
        #2;
        chk8("R5 async reset product", pa, 8'h00);
        chk8("R5 async reset valid", {7'd0, va}, 8'h00);
        chk16("R5 async reset N=8", pb, 16'h0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule